// File: doc/BRIEF.md
# Thermal Alarm with Consecutive-Fault Filter

This block watches a stream of signed 16-bit temperature samples and drives a single over-temperature alarm pin. Each accepted sample is compared against a programmable upper trip limit and a lower release (hysteresis) limit. A sample only counts toward a state change when it crosses the limit that the block is currently watching. The alarm changes state only after a programmable run of back-to-back qualifying samples, so isolated noisy readings cannot toggle the pin.

Two behaviours are selectable. In comparator mode the pin follows a thermostat: it asserts after a run of samples above the upper limit and releases after an equal run below the lower limit. In interrupt mode each qualifying run latches an event that holds until a register-read pulse clears it. The watched crossing then alternates between upper and lower. The pin polarity is programmable. A shutdown control stops sample evaluation without disturbing the stored state. The converter, the register file and the bus interface sit outside this block.

Top module: `therm_alarm`

## Requirements
- R1: `flt_sel_i` values 0, 1, 2 and 3 require runs of 1, 2, 4 and 6 consecutive qualifying samples before the alarm state changes.
- R2: An accepted sample that does not qualify restarts the run from zero.
- R3: Comparisons are signed two's complement. A sample is over when `smp_i > lim_hi_i` and under when `smp_i < lim_lo_i`; equality with either limit does not qualify.
- R4: In comparator mode (`int_mode_i`=0):
  - While inactive, a run of over samples activates the alarm.
  - While active, a run of under samples releases it.
  - Over samples while active and under samples while inactive are non-qualifying.
  - `rd_clr_i` has no effect.
- R5: In interrupt mode (`int_mode_i`=1):
  - A qualifying run latches the alarm, and the latch holds until a `rd_clr_i` pulse clears it on the next edge.
  - Each qualifying run flips the watched crossing. The first watched crossing is over, then under, and so on.
- R6: When a qualifying run completes in the same cycle as `rd_clr_i`, the alarm is set.
- R7: `alarm_o` equals the active state when `pol_hi_i`=1 and its inverse when `pol_hi_i`=0. A polarity change shows on the pin without a clock edge.
- R8: While `shdn_i`=1, samples are ignored, and a partial run count is held until evaluation resumes.
- R9: A change of `int_mode_i` clears the run count, the alarm state and the watched crossing. A sample presented in that cycle is ignored.
- R10: After reset the alarm is inactive and the run count is zero. With `pol_hi_i`=0, `alarm_o` reads 1.
- R11: The alarm state changes at the clock edge that accepts the last sample of a qualifying run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | New sample strobe, one cycle per sample |
| smp_i | input | 16 | Signed temperature sample |
| lim_hi_i | input | 16 | Signed upper trip limit |
| lim_lo_i | input | 16 | Signed lower release limit |
| flt_sel_i | input | 2 | Run length select (0:1, 1:2, 2:4, 3:6) |
| int_mode_i | input | 1 | 0 comparator mode, 1 interrupt mode |
| pol_hi_i | input | 1 | 1 active-high pin, 0 active-low pin |
| shdn_i | input | 1 | 1 stops sample evaluation |
| rd_clr_i | input | 1 | Register-read pulse, clears a latched event |
| alarm_o | output | 1 | Alarm pin level |

## Verification
The assertions assume several things about the inputs:
- `rd_clr_i` and `smp_vld_i` are single-cycle levels sampled at the clock.
- `lim_lo_i` does not exceed `lim_hi_i`.
- The limits and `flt_sel_i` are steady during a run.

The stimulus keeps to these assumptions:
- Limits change only right after a reset.
- The run-length select changes only at points where a run has just completed or where a fresh run is expected.
- Mode changes are presented on their own cycle or with a sample that the design must ignore.

// File: rtl/therm_pkg.sv
package therm_pkg;
  localparam int SMP_W = 16;
  localparam int SEL_W = 2;
  localparam int CNT_W = 3;

  // run length per select code
  function automatic logic [CNT_W-1:0] run_need(input logic [SEL_W-1:0] sel);
    case (sel)
      2'd0:    run_need = CNT_W'(1);
      2'd1:    run_need = CNT_W'(2);
      2'd2:    run_need = CNT_W'(4);
      default: run_need = CNT_W'(6);
    endcase
  endfunction
endpackage

// File: rtl/therm_cmp.sv
module therm_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] smp_i,
  input  logic [W-1:0] lim_hi_i,
  input  logic [W-1:0] lim_lo_i,
  output logic         over_o,
  output logic         under_o
);
  always_comb begin
    over_o  = $signed(smp_i) > $signed(lim_hi_i);
    under_o = $signed(smp_i) < $signed(lim_lo_i);
  end
endmodule

// File: rtl/therm_fq.sv
module therm_fq #(
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic          hit_i,
  input  logic [CW-1:0] need_i,
  output logic          trip_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q, cnt_nxt;

  assign cnt_nxt = cnt_q + CW'(1);
  assign trip_o  = step_i & hit_i & (cnt_nxt >= need_i);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || trip_o)  cnt_q <= '0;
    else if (step_i)           cnt_q <= hit_i ? cnt_nxt : '0;
  end
endmodule

// File: rtl/therm_ctl.sv
module therm_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_vld_i,
  input  logic shdn_i,
  input  logic int_mode_i,
  input  logic rd_clr_i,
  input  logic over_i,
  input  logic under_i,
  input  logic trip_i,
  output logic step_o,
  output logic hit_o,
  output logic mode_chg_o,
  output logic act_o
);
  logic mode_q, cmp_act_q, pend_q, watch_lo_q, look_lo;

  assign mode_chg_o = int_mode_i ^ mode_q;
  assign step_o     = smp_vld_i & ~shdn_i & ~mode_chg_o;
  assign look_lo    = int_mode_i ? watch_lo_q : cmp_act_q;
  assign hit_o      = look_lo ? under_i : over_i;
  assign act_o      = int_mode_i ? pend_q : cmp_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= 1'b0;
      cmp_act_q  <= 1'b0;
      pend_q     <= 1'b0;
      watch_lo_q <= 1'b0;
    end else begin
      mode_q <= int_mode_i;
      if (mode_chg_o) begin
        cmp_act_q  <= 1'b0;
        pend_q     <= 1'b0;
        watch_lo_q <= 1'b0;
      end else if (int_mode_i) begin
        // trip wins over a coincident read clear
        if (trip_i) begin
          pend_q     <= 1'b1;
          watch_lo_q <= ~watch_lo_q;
        end else if (rd_clr_i) begin
          pend_q <= 1'b0;
        end
      end else if (trip_i) begin
        cmp_act_q <= ~cmp_act_q;
      end
    end
  end
endmodule

// File: rtl/therm_alarm.sv
module therm_alarm
  import therm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_vld_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic [SMP_W-1:0] lim_hi_i,
  input  logic [SMP_W-1:0] lim_lo_i,
  input  logic [SEL_W-1:0] flt_sel_i,
  input  logic             int_mode_i,
  input  logic             pol_hi_i,
  input  logic             shdn_i,
  input  logic             rd_clr_i,
  output logic             alarm_o
);
  logic             over, under, step, hit, trip, mode_chg, act;
  logic [CNT_W-1:0] cnt, need;

  assign need = run_need(flt_sel_i);

  therm_cmp #(.W(SMP_W)) u_cmp (
    .smp_i(smp_i), .lim_hi_i(lim_hi_i), .lim_lo_i(lim_lo_i),
    .over_o(over), .under_o(under)
  );

  therm_fq #(.CW(CNT_W)) u_fq (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(mode_chg), .step_i(step),
    .hit_i(hit), .need_i(need), .trip_o(trip), .cnt_o(cnt)
  );

  therm_ctl u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_vld_i(smp_vld_i), .shdn_i(shdn_i),
    .int_mode_i(int_mode_i), .rd_clr_i(rd_clr_i), .over_i(over),
    .under_i(under), .trip_i(trip), .step_o(step), .hit_o(hit),
    .mode_chg_o(mode_chg), .act_o(act)
  );

  assign alarm_o = pol_hi_i ? act : ~act;
endmodule

// File: rtl/therm_alarm_chk.sv
module therm_alarm_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       smp_vld_i,
  input logic       shdn_i,
  input logic       int_mode_i,
  input logic       rd_clr_i,
  input logic       mode_chg,
  input logic       trip,
  input logic       act,
  input logic [2:0] cnt
);
  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < 3'd6);

  assert_shdn_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i && shdn_i && !mode_chg |=> $stable(cnt));

  assert_mode_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg |=> (cnt == 3'd0) && !act);

  assert_cmp_rd_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_mode_i && !mode_chg && rd_clr_i && !trip |=> int_mode_i || $stable(act));

  assert_int_rd_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_mode_i && !mode_chg && rd_clr_i && !trip |=> !int_mode_i || !act);

  assert_trip_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_mode_i && !mode_chg && trip |=> !int_mode_i || act);
endmodule

bind therm_alarm therm_alarm_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .smp_vld_i(smp_vld_i), .shdn_i(shdn_i),
  .int_mode_i(int_mode_i), .rd_clr_i(rd_clr_i), .mode_chg(mode_chg),
  .trip(trip), .act(act), .cnt(cnt)
);

// File: tb/therm_alarm_bench.sv
module therm_alarm_bench;
  localparam int CLK_P = 10;
  localparam logic [15:0] HI = 16'h1900, LO = 16'h1400;
  localparam logic [15:0] OV = 16'h1A00, UN = 16'h1300, MD = 16'h1600;
  localparam int NV = 28;
  // {mode, pol, sel[1:0], vld, rd, smp[15:0], exp_alarm}
  localparam logic [22:0] VEC [NV] = '{
    {1'b0,1'b0,2'd1,1'b1,1'b0,OV,1'b1},     // R1 run 1 of 2
    {1'b0,1'b0,2'd1,1'b1,1'b0,MD,1'b1},     // R2 restart
    {1'b0,1'b0,2'd1,1'b1,1'b0,OV,1'b1},
    {1'b0,1'b0,2'd1,1'b1,1'b0,OV,1'b0},     // R4 assert (low-active)
    {1'b0,1'b0,2'd1,1'b1,1'b0,MD,1'b0},
    {1'b0,1'b0,2'd1,1'b0,1'b1,MD,1'b0},     // R4 read ignored
    {1'b0,1'b0,2'd1,1'b1,1'b0,UN,1'b0},
    {1'b0,1'b0,2'd1,1'b1,1'b0,OV,1'b0},     // R4 over while active restarts
    {1'b0,1'b0,2'd1,1'b1,1'b0,UN,1'b0},
    {1'b0,1'b0,2'd1,1'b1,1'b0,UN,1'b1},     // R4 release
    {1'b0,1'b0,2'd3,1'b1,1'b0,OV,1'b1},     // R1 run of 6
    {1'b0,1'b0,2'd3,1'b1,1'b0,OV,1'b1},
    {1'b0,1'b0,2'd3,1'b1,1'b0,OV,1'b1},
    {1'b0,1'b0,2'd3,1'b1,1'b0,OV,1'b1},
    {1'b0,1'b0,2'd3,1'b1,1'b0,OV,1'b1},
    {1'b0,1'b0,2'd3,1'b1,1'b0,OV,1'b0},
    {1'b0,1'b1,2'd3,1'b0,1'b0,MD,1'b1},     // R7 active high
    {1'b0,1'b1,2'd0,1'b1,1'b0,UN,1'b0},
    {1'b0,1'b1,2'd0,1'b1,1'b0,OV,1'b1},
    {1'b1,1'b1,2'd0,1'b1,1'b0,OV,1'b0},     // R9 mode change clears
    {1'b1,1'b1,2'd0,1'b1,1'b0,OV,1'b1},     // R5 latch
    {1'b1,1'b1,2'd0,1'b1,1'b0,OV,1'b1},
    {1'b1,1'b1,2'd0,1'b0,1'b1,MD,1'b0},     // R5 read clears
    {1'b1,1'b1,2'd0,1'b1,1'b0,OV,1'b0},     // R5 now watching under
    {1'b1,1'b1,2'd0,1'b1,1'b0,UN,1'b1},
    {1'b1,1'b1,2'd0,1'b0,1'b1,MD,1'b0},
    {1'b1,1'b1,2'd0,1'b0,1'b0,MD,1'b0},
    {1'b0,1'b1,2'd0,1'b0,1'b0,MD,1'b0}      // R9 back to comparator
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic vld = 1'b0, mode = 1'b0, pol = 1'b0, shdn = 1'b0, rd = 1'b0;
  logic [15:0] smp = '0, hi = HI, lo = LO;
  logic [1:0] sel = '0;
  logic alarm;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  therm_alarm u_therm_alarm (
    .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(vld), .smp_i(smp),
    .lim_hi_i(hi), .lim_lo_i(lo), .flt_sel_i(sel), .int_mode_i(mode),
    .pol_hi_i(pol), .shdn_i(shdn), .rd_clr_i(rd), .alarm_o(alarm)
  );

  task automatic check(input logic exp, input string tag);
    total++;
    if (alarm !== exp) begin
      bad++;
      $display("FAIL %s: alarm_o=%b expected %b", tag, alarm, exp);
    end
  endtask

  task automatic step(input logic v, input logic [15:0] s, input logic r);
    vld = v; smp = s; rd = r;
    @(posedge clk);
    #2;
    vld = 1'b0; rd = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; vld = 1'b0; rd = 1'b0; mode = 1'b0; shdn = 1'b0;
    #(CLK_P*2);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(CLK_P*100000);
    bad++; total++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R10 reset state
    #(CLK_P*2);
    check(1'b1, "R10 reset, active-low idle");
    pol = 1'b1; #1;
    check(1'b0, "R10 reset, active-high idle");
    pol = 1'b0;
    do_reset();

    for (int i = 0; i < NV; i++) begin
      mode = VEC[i][22]; pol = VEC[i][21]; sel = VEC[i][20:19];
      step(VEC[i][18], VEC[i][16:1], VEC[i][17]);
      check(VEC[i][0], $sformatf("table[%0d]", i));
    end

    // R1 / R11: run of 4, alarm moves on the 4th edge only
    do_reset(); pol = 1'b1; sel = 2'd2;
    for (int k = 0; k < 3; k++) begin
      step(1'b1, OV, 1'b0);
      check(1'b0, "R1 run of 4 not yet complete");
    end
    vld = 1'b1; smp = OV; #1;
    check(1'b0, "R11 no change before edge");
    step(1'b1, OV, 1'b0);
    check(1'b1, "R11 change at 4th edge");
    pol = 1'b0; #1;
    check(1'b0, "R7 polarity flips without clock");

    // R6: trip coincident with read clear
    do_reset(); pol = 1'b1; sel = 2'd0; mode = 1'b1;
    step(1'b0, MD, 1'b0);
    step(1'b1, OV, 1'b1);
    check(1'b1, "R6 trip beats read clear");

    // R8: shutdown holds partial count
    do_reset(); pol = 1'b1; sel = 2'd1;
    step(1'b1, OV, 1'b0);
    shdn = 1'b1;
    step(1'b1, MD, 1'b0);
    step(1'b1, OV, 1'b0);
    check(1'b0, "R8 samples ignored in shutdown");
    shdn = 1'b0;
    step(1'b1, OV, 1'b0);
    check(1'b1, "R8 held count completes run");

    // R3: signed compare and equality
    do_reset(); pol = 1'b1; sel = 2'd0; hi = 16'hFF00; lo = 16'hFE00;
    step(1'b1, 16'hFF00, 1'b0);
    check(1'b0, "R3 equal to upper not over");
    step(1'b1, 16'h0000, 1'b0);
    check(1'b1, "R3 zero above negative limit");
    step(1'b1, 16'hFE00, 1'b0);
    check(1'b1, "R3 equal to lower not under");
    step(1'b1, 16'h8000, 1'b0);
    check(1'b0, "R3 most negative below lower");
    hi = HI; lo = LO;

    // R9: mode change mid-run clears count, sample ignored
    do_reset(); pol = 1'b1; sel = 2'd1;
    step(1'b1, OV, 1'b0);
    mode = 1'b1;
    step(1'b1, OV, 1'b0);
    check(1'b0, "R9 change-cycle sample ignored");
    step(1'b1, OV, 1'b0);
    check(1'b0, "R9 count restarted");
    step(1'b1, OV, 1'b0);
    check(1'b1, "R9 fresh run completes");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule